// File: doc/BRIEF.md
# Rotated-Immediate Operand Codec

This block translates between full-width constants and the compact 12-bit immediate operand field used by data-processing instructions of a common 32-bit load/store architecture. In that field, a 4-bit rotate amount sits in bits 11:8 and an 8-bit payload sits in bits 7:0. The operand value is the payload zero-extended and rotated right by twice the rotate amount. It is never shifted. In an instruction word, bit 25 chooses this immediate form, and the field itself occupies bits 11:0. This block handles only the 12-bit field.

The decode side is purely combinational. It expands a field into its 32-bit value and also gives the shifter carry that the operand produces. The encode side is sequential. After a start pulse it tries the sixteen rotate amounts, one per clock and in ascending order, and stops at the first one that reproduces the constant. Because of that order, the reported field is always the canonical one, meaning the one with the smallest rotate amount. A constant that no rotation can produce is flagged and gives a zero field.

Top module: `rotimm_codec`

## Requirements
- R1: The decoded value equals the 8-bit payload `dec_field[7:0]`, zero-extended to 32 bits and rotated right by 2×`dec_field[11:8]`. For example, field 0x808 decodes to 0x00080000.
- R2: The decode carry equals `carry_in` when `dec_field[11:8]` is 0. Otherwise it equals bit 31 of the decoded value.
- R3: When encoding finishes with `enc_ok`=1, decoding `enc_field` by the rule of R1 gives back the constant that was presented with the accepted start.
- R4: Among all fields that represent the constant, the encoder reports the one with the smallest rotate amount. For example, 0x00080000 encodes as 0x702, not 0x808.
- R5: For a constant that no field represents, the encoder finishes with `enc_not_encodable`=1, `enc_ok`=0 and `enc_field`=0.
- R6: `enc_done` is a one-cycle pulse. It arrives r+1 rising edges after the edge that accepted start, where r is the reported rotate amount. For an unencodable constant it arrives 16 edges after that edge.
- R7: A start while `enc_busy` is high is ignored. The result reflects the constant that was accepted first.
- R8: After reset, `enc_busy`, `enc_done`, `enc_ok` and `enc_not_encodable` are 0, and `enc_field` is 0.
- R9: `enc_busy` goes high on the edge that accepts a start. It stays high until the edge that raises `enc_done`, and at that edge it falls.
- R10: `enc_ok` and `enc_not_encodable` are never both high, and they hold their value from one `enc_done` until the next.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| dec_field | input | 12 | Field to expand: rotate amount in [11:8], payload in [7:0] |
| carry_in | input | 1 | Incoming carry flag, passed through when the rotate amount is zero |
| dec_value | output | 32 | Expanded constant |
| dec_carry | output | 1 | Shifter carry-out of the expanded constant |
| enc_start | input | 1 | Starts an encode search when the encoder is idle |
| enc_const | input | 32 | Constant to encode, sampled with an accepted start |
| enc_busy | output | 1 | Search in progress |
| enc_done | output | 1 | One-cycle pulse at the end of a search |
| enc_ok | output | 1 | The last search found a representation |
| enc_not_encodable | output | 1 | The last search found no representation |
| enc_field | output | 12 | Canonical field found by the last search, 0 when none |

## Verification
A wrong rotate counter or a stale captured constant shows up at the ports in two ways. `enc_done` arrives a different number of cycles after start than the reported rotate amount predicts, or `enc_field` decodes to a different constant. Either is visible on the same cycle that `enc_done` pulses. A wrong rotate-direction or carry-select term in the expander corrupts `dec_value` or `dec_carry` combinationally for some field, so a sweep over all 4096 fields and both carry inputs exposes it immediately. A start that leaks in while busy replaces the captured constant, and the encoder then reports a field for the wrong value at the next done.

// File: rtl/rotimm_pkg.sv
// Shared definitions for the rotated-immediate codec.
// Assumes the rotation step is two bit positions per unit of rotate amount.
package rotimm_pkg;
    typedef enum logic [0:0] {
        SCAN_IDLE = 1'b0,
        SCAN_RUN  = 1'b1
    } scan_state_t;

    localparam int ROT_STEP = 2;
endpackage

// File: rtl/rotimm_expand.sv
// Expands a rotate/payload field into a full-width constant and the carry the
// rotation produces. Purely combinational.
// Assumes 2*(2**ROT_W-1) < WORD_W so every rotation amount is below the word width.
module rotimm_expand #(
    parameter int WORD_W = 32,
    parameter int IMM_W  = 8,
    parameter int ROT_W  = 4,
    localparam int FIELD_W = ROT_W + IMM_W,
    localparam int AMT_W   = ROT_W + 1
) (
    input  logic [FIELD_W-1:0] field,
    input  logic               carry_in,
    output logic [WORD_W-1:0]  value,
    output logic               carry_out
);
    logic [ROT_W-1:0]    rot;
    logic [AMT_W-1:0]    amt;
    logic [WORD_W-1:0]   payload;
    logic [2*WORD_W-1:0] doubled;

    // Split the field and form the rotate-right amount in bit positions.
    always_comb begin
        rot     = field[FIELD_W-1:IMM_W];
        amt     = {rot, 1'b0};
        payload = {{(WORD_W-IMM_W){1'b0}}, field[IMM_W-1:0]};
    end

    // Rotate right by shifting a doubled copy and keeping the low half.
    always_comb begin
        doubled = {payload, payload} >> amt;
        value   = doubled[WORD_W-1:0];
    end

    // The carry passes through for a zero rotation, else it is the top bit.
    always_comb begin
        carry_out = (rot == '0) ? carry_in : value[WORD_W-1];
    end
endmodule

// File: rtl/rotimm_match.sv
// Tests whether a constant is some payload rotated right by 2*rot. It undoes
// the rotation by rotating the constant left by the same amount and checks
// that only the payload bits remain. Purely combinational.
module rotimm_match #(
    parameter int WORD_W = 32,
    parameter int IMM_W  = 8,
    parameter int ROT_W  = 4,
    localparam int AMT_W = ROT_W + 1
) (
    input  logic [WORD_W-1:0] constant,
    input  logic [ROT_W-1:0]  rot,
    output logic              hit,
    output logic [IMM_W-1:0]  imm
);
    logic [AMT_W-1:0]    amt;
    logic [2*WORD_W-1:0] doubled;
    logic [WORD_W-1:0]   unrolled;

    // Rotate left by 2*rot: the high half of a shifted doubled copy.
    always_comb begin
        amt      = {rot, 1'b0};
        doubled  = {constant, constant} << amt;
        unrolled = doubled[2*WORD_W-1:WORD_W];
    end

    // A match means every bit above the payload is zero after unrolling.
    always_comb begin
        hit = (unrolled[WORD_W-1:IMM_W] == '0);
        imm = unrolled[IMM_W-1:0];
    end
endmodule

// File: rtl/rotimm_search.sv
// Sequential encoder. It captures a constant on start and tries one rotate
// amount per clock from 0 upward. It stops at the first hit (the canonical
// field) or after the last amount (not encodable). Start is ignored while a
// search runs. The results hold until the next search ends.
module rotimm_search
    import rotimm_pkg::*;
#(
    parameter int WORD_W = 32,
    parameter int IMM_W  = 8,
    parameter int ROT_W  = 4,
    localparam int FIELD_W = ROT_W + IMM_W,
    localparam logic [ROT_W-1:0] ROT_LAST = '1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [WORD_W-1:0]  constant,
    output logic               busy,
    output logic               done,
    output logic               ok,
    output logic               not_encodable,
    output logic [FIELD_W-1:0] field
);
    scan_state_t        state_q;
    logic [WORD_W-1:0]  const_q;
    logic [ROT_W-1:0]   rot_q;
    logic               done_q;
    logic               ok_q;
    logic               nenc_q;
    logic [FIELD_W-1:0] field_q;
    logic               hit;
    logic [IMM_W-1:0]   imm;

    // Candidate test for the rotate amount under trial this cycle.
    rotimm_match #(
        .WORD_W(WORD_W),
        .IMM_W (IMM_W),
        .ROT_W (ROT_W)
    ) u_match (
        .constant(const_q),
        .rot     (rot_q),
        .hit     (hit),
        .imm     (imm)
    );

    // Search control: capture, step the rotation, and record the result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SCAN_IDLE;
            const_q <= '0;
            rot_q   <= '0;
            done_q  <= 1'b0;
            ok_q    <= 1'b0;
            nenc_q  <= 1'b0;
            field_q <= '0;
        end else begin
            done_q <= 1'b0;
            case (state_q)
                SCAN_IDLE: begin
                    if (start) begin
                        const_q <= constant;
                        rot_q   <= '0;
                        state_q <= SCAN_RUN;
                    end
                end
                SCAN_RUN: begin
                    if (hit) begin
                        field_q <= {rot_q, imm};
                        ok_q    <= 1'b1;
                        nenc_q  <= 1'b0;
                        done_q  <= 1'b1;
                        state_q <= SCAN_IDLE;
                    end else if (rot_q == ROT_LAST) begin
                        field_q <= '0;
                        ok_q    <= 1'b0;
                        nenc_q  <= 1'b1;
                        done_q  <= 1'b1;
                        state_q <= SCAN_IDLE;
                    end else begin
                        rot_q <= rot_q + 1'b1;
                    end
                end
                default: state_q <= SCAN_IDLE;
            endcase
        end
    end

    // Drive the outputs straight from the registers.
    always_comb begin
        busy          = (state_q == SCAN_RUN);
        done          = done_q;
        ok            = ok_q;
        not_encodable = nenc_q;
        field         = field_q;
    end
endmodule

// File: rtl/rotimm_codec.sv
// Top of the rotated-immediate codec. It joins the combinational field
// expander and the one-rotation-per-clock encoder. The two paths share
// nothing and can be used at the same time.
module rotimm_codec #(
    parameter int WORD_W = 32,
    parameter int IMM_W  = 8,
    parameter int ROT_W  = 4,
    localparam int FIELD_W = ROT_W + IMM_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [FIELD_W-1:0] dec_field,
    input  logic               carry_in,
    output logic [WORD_W-1:0]  dec_value,
    output logic               dec_carry,
    input  logic               enc_start,
    input  logic [WORD_W-1:0]  enc_const,
    output logic               enc_busy,
    output logic               enc_done,
    output logic               enc_ok,
    output logic               enc_not_encodable,
    output logic [FIELD_W-1:0] enc_field
);
    // Field to constant.
    rotimm_expand #(
        .WORD_W(WORD_W),
        .IMM_W (IMM_W),
        .ROT_W (ROT_W)
    ) u_expand (
        .field    (dec_field),
        .carry_in (carry_in),
        .value    (dec_value),
        .carry_out(dec_carry)
    );

    // Constant to canonical field.
    rotimm_search #(
        .WORD_W(WORD_W),
        .IMM_W (IMM_W),
        .ROT_W (ROT_W)
    ) u_search (
        .clk          (clk),
        .rst_n        (rst_n),
        .start        (enc_start),
        .constant     (enc_const),
        .busy         (enc_busy),
        .done         (enc_done),
        .ok           (enc_ok),
        .not_encodable(enc_not_encodable),
        .field        (enc_field)
    );
endmodule

// File: rtl/rotimm_codec_chk.sv
// Port-level checker for rotimm_codec, attached by bind. It watches the
// handshake, the result flags and the decode carry selection.
module rotimm_codec_chk #(
    parameter int WORD_W = 32,
    parameter int IMM_W  = 8,
    parameter int ROT_W  = 4,
    localparam int FIELD_W = ROT_W + IMM_W,
    localparam int STEPS   = 1 << ROT_W,
    localparam int CNT_W   = ROT_W + 2
) (
    input logic               clk,
    input logic               rst_n,
    input logic [FIELD_W-1:0] dec_field,
    input logic               carry_in,
    input logic [WORD_W-1:0]  dec_value,
    input logic               dec_carry,
    input logic               enc_start,
    input logic               enc_busy,
    input logic               enc_done,
    input logic               enc_ok,
    input logic               enc_not_encodable,
    input logic [FIELD_W-1:0] enc_field
);
    logic [CNT_W-1:0] busy_run;

    // Count consecutive busy cycles to bound the search length.
    always_ff @(posedge clk) begin
        if (!rst_n) busy_run <= '0;
        else        busy_run <= enc_busy ? busy_run + 1'b1 : '0;
    end

    assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        enc_done |=> !enc_done);
    assert_busy_bounded_R6: assert property (@(posedge clk) disable iff (!rst_n)
        enc_busy |-> (busy_run < CNT_W'(STEPS)));
    assert_start_accept_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (enc_start && !enc_busy) |=> enc_busy);
    assert_done_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        enc_done |-> !enc_busy);
    assert_flags_exclusive_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(enc_ok && enc_not_encodable));
    assert_flags_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !enc_done |-> ($stable(enc_ok) && $stable(enc_not_encodable)
                       && $stable(enc_field)));
    assert_nenc_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        enc_not_encodable |-> (enc_field == '0));
    assert_carry_pass_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_field[FIELD_W-1:IMM_W] == '0) |-> (dec_carry == carry_in));
    assert_carry_top_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_field[FIELD_W-1:IMM_W] != '0) |-> (dec_carry == dec_value[WORD_W-1]));
endmodule

bind rotimm_codec rotimm_codec_chk #(
    .WORD_W(WORD_W),
    .IMM_W (IMM_W),
    .ROT_W (ROT_W)
) u_rotimm_codec_chk (
    .clk              (clk),
    .rst_n            (rst_n),
    .dec_field        (dec_field),
    .carry_in         (carry_in),
    .dec_value        (dec_value),
    .dec_carry        (dec_carry),
    .enc_start        (enc_start),
    .enc_busy         (enc_busy),
    .enc_done         (enc_done),
    .enc_ok           (enc_ok),
    .enc_not_encodable(enc_not_encodable),
    .enc_field        (enc_field)
);

// File: tb/test_rotimm_codec.sv
`timescale 1ns/1ps
module test_rotimm_codec;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] dec_field = '0;
    logic        carry_in = 1'b0;
    logic [31:0] dec_value;
    logic        dec_carry;
    logic        enc_start = 1'b0;
    logic [31:0] enc_const = '0;
    logic        enc_busy;
    logic        enc_done;
    logic        enc_ok;
    logic        enc_not_encodable;
    logic [11:0] enc_field;

    int checks = 0;
    int fails  = 0;
    logic [31:0] seed = 32'h1234_5678;

    always #5 clk = ~clk;

    rotimm_codec i_rotimm_codec (
        .clk(clk), .rst_n(rst_n),
        .dec_field(dec_field), .carry_in(carry_in),
        .dec_value(dec_value), .dec_carry(dec_carry),
        .enc_start(enc_start), .enc_const(enc_const),
        .enc_busy(enc_busy), .enc_done(enc_done), .enc_ok(enc_ok),
        .enc_not_encodable(enc_not_encodable), .enc_field(enc_field)
    );

    function automatic logic [31:0] ref_ror(input logic [31:0] v, input int a);
        if (a == 0) return v;
        return (v >> a) | (v << (32 - a));
    endfunction

    function automatic logic [31:0] ref_decode(input logic [11:0] f);
        return ref_ror({24'd0, f[7:0]}, 2 * int'(f[11:8]));
    endfunction

    // Brute force over all 4096 fields, smallest rotate amount first.
    function automatic logic [12:0] ref_encode(input logic [31:0] c);
        for (int r = 0; r < 16; r++)
            for (int i = 0; i < 256; i++)
                if (ref_ror(i, 2 * r) == c) return {1'b1, 4'(r), 8'(i)};
        return 13'd0;
    endfunction

    task automatic check(input string req, input logic ok, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic next_rand();
        seed = seed * 32'd1103515245 + 32'd12345;
    endtask

    // Run one encode. Optionally inject a competing start while busy.
    task automatic run_encode(input logic [31:0] c, input bit inject);
        logic [12:0] exp;
        int n;
        int exp_n;
        exp = ref_encode(c);
        exp_n = exp[12] ? int'(exp[11:8]) + 1 : 16;
        @(negedge clk);
        enc_start = 1'b1;
        enc_const = c;
        @(posedge clk);
        #1;
        enc_start = 1'b0;
        check("R9 busy after start", enc_busy === 1'b1, 32'(enc_busy), 32'd1);
        if (inject && enc_busy) begin
            enc_start = 1'b1;
            enc_const = ~c;
        end
        n = 0;
        while (n < 20) begin
            @(posedge clk);
            #1;
            enc_start = 1'b0;
            n++;
            if (enc_done) break;
        end
        check("R6 done latency", n == exp_n, 32'(n), 32'(exp_n));
        check("R9 busy low at done", enc_busy === 1'b0, 32'(enc_busy), 32'd0);
        if (exp[12]) begin
            check(inject ? "R7 ignored start, field" : "R4 canonical field",
                  enc_ok === 1'b1 && enc_field === exp[11:0],
                  32'(enc_field), 32'(exp[11:0]));
            check("R3 field decodes back", ref_decode(enc_field) === c,
                  ref_decode(enc_field), c);
        end else begin
            check("R5 not encodable", enc_not_encodable === 1'b1 && enc_ok === 1'b0
                  && enc_field === 12'd0, {19'd0, enc_not_encodable, enc_field}, 32'h1000);
        end
        check("R10 flags exclusive", !(enc_ok && enc_not_encodable),
              32'(enc_ok), 32'(!enc_not_encodable));
        @(posedge clk);
        #1;
        check("R6 done single cycle", enc_done === 1'b0, 32'(enc_done), 32'd0);
        check("R10 flags held", enc_ok === exp[12] && enc_field === exp[11:0],
              32'(enc_field), 32'(exp[11:0]));
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        #2_000_000;
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check("R8 reset state", {enc_busy, enc_done, enc_ok, enc_not_encodable} === 4'b0
              && enc_field === 12'd0, {16'd0, enc_busy, enc_done, enc_ok,
              enc_not_encodable, enc_field}, 32'd0);
        @(negedge clk);
        rst_n = 1'b1;

        // R1 R2: exhaustive decode sweep.
        for (int f = 0; f < 4096; f++) begin
            for (int ci = 0; ci < 2; ci++) begin
                logic [31:0] ev;
                logic        ec;
                dec_field = 12'(f);
                carry_in  = ci[0];
                #1;
                ev = ref_decode(12'(f));
                ec = (f[11:8] == 0) ? ci[0] : ev[31];
                check("R1 decode value", dec_value === ev, dec_value, ev);
                check("R2 decode carry", dec_carry === ec, 32'(dec_carry), 32'(ec));
            end
        end
        dec_field = 12'h808;
        #1;
        check("R1 field 0x808", dec_value === 32'h0008_0000, dec_value, 32'h0008_0000);

        // R4 canonical choice for the rotated-by-16 example.
        run_encode(32'h0008_0000, 1'b0);
        check("R4 0x00080000 gives 0x702", enc_field === 12'h702, 32'(enc_field), 32'h702);
        run_encode(32'h0000_0000, 1'b0);
        run_encode(32'h0000_00FF, 1'b0);
        run_encode(32'hF000_000F, 1'b0);
        run_encode(32'h0000_0100, 1'b0);
        run_encode(32'hFF00_0000, 1'b0);
        run_encode(32'h0000_0101, 1'b0);
        run_encode(32'hFFFF_FFFF, 1'b0);
        run_encode(32'h1FE0_0000, 1'b0);
        // R7: competing starts during long searches.
        run_encode(32'h0000_3FC0, 1'b1);
        run_encode(32'h1234_5678, 1'b1);
        run_encode(32'hC000_003F, 1'b1);

        // Constants built from random fields, then raw random words.
        for (int k = 0; k < 80; k++) begin
            next_rand();
            run_encode(ref_decode(seed[19:8]), k[0]);
        end
        for (int k = 0; k < 24; k++) begin
            next_rand();
            run_encode(seed, 1'b0);
        end

        // R8: reset clears results mid-search.
        @(negedge clk);
        enc_start = 1'b1;
        enc_const = 32'h0000_0101;
        @(negedge clk);
        enc_start = 1'b0;
        rst_n = 1'b0;
        @(posedge clk);
        #1;
        check("R8 reset mid-search", {enc_busy, enc_done, enc_ok, enc_not_encodable} === 4'b0
              && enc_field === 12'd0, {16'd0, enc_busy, enc_done, enc_ok,
              enc_not_encodable, enc_field}, 32'd0);
        finish_run();
    end
endmodule